// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital sequencing logic around a successive-approximation converter. It runs on the system clock and derives a slower converter clock from it with a prescaler that can be reloaded. It decides when a conversion starts and counts its cycles. It issues a one-cycle strobe at the sample-and-hold instant and a one-cycle select-latch pulse when each conversion starts. When the conversion ends, it loads the result and raises a completion flag. The analog comparator and DAC are not modelled. The converted value arrives on a behavioural data input, and the block captures it at the sample strobe.

Software drives an enable, a start bit, a mode field (single, free running, triggered) and a prescaler select. A triggered conversion is started by a synchronised rising edge on an external trigger pin. That edge reloads the prescaler, so the delay from the trigger to the sample instant is fixed. The first conversion after enable is stretched to allow the analog circuits to settle. Dropping enable abandons the conversion in progress.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The converter clock period is 2^(presc_sel+1) system cycles for presc_sel 0..6 and 128 cycles for presc_sel 7. While en is low the converter clock stays low.
- R2: A start write (a start_set pulse) begins a conversion at the next rising converter-clock edge. The sel_pulse output marks that start and follows the write by 1 to one divide period of system cycles.
- R3: A normal conversion lasts 13 converter cycles: done_flag rises 13 divide periods after sel_pulse.
- R4: The first conversion after en rises lasts 25 converter cycles.
- R5: sample_stb appears 3.5 converter cycles after sel_pulse in a normal conversion and 13.5 in a first conversion. result holds the data_in value present at that strobe.
- R6: result and done_flag update in the same cycle. A flag_clr pulse clears done_flag, and a completion in the same cycle takes precedence over the clear.
- R7: In single mode (mode 0), start_bit drops in the same cycle that done_flag rises.
- R8: In free-running mode (mode 1), the next conversion begins in the same cycle that the previous one completes. start_bit stays high, and the follow-on conversion lasts 13 cycles.
- R9: In triggered mode (mode 2), a rising edge on trig_in reloads the prescaler and starts a conversion 4 system-clock edges later. sample_stb follows sel_pulse by two converter cycles, and done_flag follows it by 11.5 converter cycles.
- R10: trig_in edges do nothing while a conversion is running and do nothing in modes other than 2.
- R11: Dropping en aborts the conversion in progress without setting done_flag and clears start_bit. The next conversion is then a first conversion.
- R12: sel_in is copied to sel_latched at the start of each conversion. Later changes to sel_in do not affect the running conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| start_set | input | 1 | One-cycle write that sets the start bit |
| mode | input | 2 | 0 single, 1 free running, 2 triggered, 3 as single |
| presc_sel | input | 3 | Prescaler divide select |
| trig_in | input | 1 | Asynchronous trigger source |
| flag_clr | input | 1 | Write-one pulse that clears done_flag |
| sel_in | input | 4 | Channel/reference selection to be latched |
| data_in | input | 10 | Behavioural converter value |
| adc_clk | output | 1 | Converter clock |
| start_bit | output | 1 | Start bit state |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Completion flag |
| result | output | 10 | Conversion result |
| sample_stb | output | 1 | Sample-and-hold strobe |
| sel_latched | output | 4 | Selection in force for this conversion |
| sel_pulse | output | 1 | One-cycle pulse at conversion start |

## Verification
sel_pulse and sample_stb leave the same register stage, so the bench measures the strobe 3.5, 13.5 or 2 divide periods after sel_pulse. It expects done_flag 13, 25 or 11.5 periods after sel_pulse, and the triggered sel_pulse 4 clock edges after trig_in is raised. A free-running cycle counter is incremented on the rising edge, and every output is read on the falling edge, so each timing result is an exact difference of counter values. The bench also checks that data changed after the strobe or selections changed after the start do not reach result or sel_latched.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_TRIG   = 2'd2,
    MODE_RSVD   = 2'd3
  } conv_mode_t;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int PSEL_W = 3,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PSEL_W-1:0] sel,
  input  logic              load_half,
  output logic              rise,
  output logic              fall,
  output logic              adc_clk
);
  localparam int DIV_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [DIV_W-1:0] div_w, half_w;
  int               lg;

  always_comb begin
    lg     = (int'(sel) >= CNT_W - 1) ? CNT_W : int'(sel) + 1;
    div_w  = DIV_W'(1) << lg;
    half_w = div_w >> 1;
    rise   = en && ({1'b0, cnt} >= div_w - 1'b1);
    fall   = en && ({1'b0, cnt} == half_w - 1'b1);
    if (!en)            cnt_nxt = '0;
    else if (load_half) cnt_nxt = half_w[CNT_W-1:0];
    else if (rise)      cnt_nxt = '0;
    else                cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      adc_clk <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      adc_clk <= en && ({1'b0, cnt_nxt} < half_w);
    end
  end

  // R1: a disabled prescaler sits at zero with the clock low
  p_off_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && !adc_clk));
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic edge_o
);
  logic m0, m1, m2;

  always_ff @(posedge clk) begin
    if (rst) begin
      {m0, m1, m2} <= 3'b000;
      edge_o       <= 1'b0;
    end else begin
      m0     <= trig_in;
      m1     <= m0;
      m2     <= m1;
      edge_o <= m1 & ~m2;
    end
  end

  // R9: the synchronised edge is a single-cycle pulse
  p_trig_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int SEL_W      = 4,
  parameter int CYC_W      = 5,
  parameter int NORM_CYC   = 13,
  parameter int FIRST_CYC  = 25,
  parameter int NORM_SAMP  = 4,
  parameter int FIRST_SAMP = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start_set,
  input  conv_mode_t       mode,
  input  logic             trig_edge,
  input  logic             flag_clr,
  input  logic [SEL_W-1:0] sel_in,
  input  logic [RES_W-1:0] data_in,
  input  logic             rise,
  input  logic             fall,
  output logic             presc_load,
  output logic             start_bit,
  output logic             busy,
  output logic             done_flag,
  output logic [RES_W-1:0] result,
  output logic             sample_stb,
  output logic [SEL_W-1:0] sel_latched,
  output logic             sel_pulse
);
  logic [CYC_W-1:0] cyc, len, scyc;
  logic             cur_first, first_pend;
  logic [RES_W-1:0] samp;
  logic             at_end;

  always_comb begin
    len        = cur_first ? CYC_W'(FIRST_CYC)  : CYC_W'(NORM_CYC);
    scyc       = cur_first ? CYC_W'(FIRST_SAMP) : CYC_W'(NORM_SAMP);
    presc_load = en && (mode == MODE_TRIG) && trig_edge && !busy;
    at_end     = busy && rise && (cyc == len);
  end

  always_ff @(posedge clk) begin
    sample_stb <= 1'b0;
    sel_pulse  <= 1'b0;
    if (rst) begin
      busy        <= 1'b0;
      cyc         <= '0;
      cur_first   <= 1'b0;
      first_pend  <= 1'b1;
      start_bit   <= 1'b0;
      done_flag   <= 1'b0;
      result      <= '0;
      samp        <= '0;
      sel_latched <= '0;
    end else if (!en) begin
      busy       <= 1'b0;
      cyc        <= '0;
      first_pend <= 1'b1;
      start_bit  <= 1'b0;
      if (flag_clr) done_flag <= 1'b0;
    end else begin
      if (start_set) start_bit <= 1'b1;
      if (flag_clr)  done_flag <= 1'b0;
      if (presc_load) begin
        busy        <= 1'b1;
        cyc         <= CYC_W'(2);
        cur_first   <= first_pend;
        first_pend  <= 1'b0;
        sel_latched <= sel_in;
        sel_pulse   <= 1'b1;
      end else if (rise) begin
        if (busy) begin
          if (cyc == len) begin
            result    <= samp;
            done_flag <= 1'b1;
            if (mode == MODE_FREE && start_bit) begin
              cyc         <= CYC_W'(1);
              cur_first   <= 1'b0;
              sel_latched <= sel_in;
              sel_pulse   <= 1'b1;
            end else begin
              busy      <= 1'b0;
              cyc       <= '0;
              start_bit <= 1'b0;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end else if (start_bit) begin
          busy        <= 1'b1;
          cyc         <= CYC_W'(1);
          cur_first   <= first_pend;
          first_pend  <= 1'b0;
          sel_latched <= sel_in;
          sel_pulse   <= 1'b1;
        end
      end
      if (fall && busy && cyc == scyc) begin
        samp       <= data_in;
        sample_stb <= 1'b1;
      end
    end
  end

  // R3: the cycle index stays inside the conversion length
  p_cyc_range_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cyc >= CYC_W'(1) && cyc <= len));
  // R5: the strobe only occurs while a conversion runs
  p_stb_busy_r5: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> busy);
  // R7: single-mode completion sets the flag and drops the start bit
  p_single_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (en && at_end && mode == MODE_SINGLE && !presc_load) |=> (done_flag && !start_bit && !busy));
  // R8: free-running completion restarts at once
  p_free_cont_r8: assert property (@(posedge clk) disable iff (rst)
    (en && at_end && mode == MODE_FREE && start_bit) |=> (busy && start_bit && sel_pulse));
  // R11: disabling abandons the conversion
  p_abort_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!busy && !start_bit));
  // R12: the selection latch pulse only marks a running conversion
  p_sel_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    sel_pulse |-> busy);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int SEL_W  = 4,
  parameter int PSEL_W = 3,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start_set,
  input  logic [1:0]        mode,
  input  logic [PSEL_W-1:0] presc_sel,
  input  logic              trig_in,
  input  logic              flag_clr,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [RES_W-1:0]  data_in,
  output logic              adc_clk,
  output logic              start_bit,
  output logic              busy,
  output logic              done_flag,
  output logic [RES_W-1:0]  result,
  output logic              sample_stb,
  output logic [SEL_W-1:0]  sel_latched,
  output logic              sel_pulse
);
  logic rise, fall, load_half, trig_edge;

  adc_prescaler #(.PSEL_W(PSEL_W), .CNT_W(CNT_W)) presc_i (
    .clk(clk), .rst(rst), .en(en), .sel(presc_sel), .load_half(load_half),
    .rise(rise), .fall(fall), .adc_clk(adc_clk)
  );

  adc_trig_sync sync_i (
    .clk(clk), .rst(rst), .trig_in(trig_in), .edge_o(trig_edge)
  );

  adc_conv_seq #(.RES_W(RES_W), .SEL_W(SEL_W)) seq_i (
    .clk(clk), .rst(rst), .en(en), .start_set(start_set),
    .mode(conv_mode_t'(mode)), .trig_edge(trig_edge), .flag_clr(flag_clr),
    .sel_in(sel_in), .data_in(data_in), .rise(rise), .fall(fall),
    .presc_load(load_half), .start_bit(start_bit), .busy(busy),
    .done_flag(done_flag), .result(result), .sample_stb(sample_stb),
    .sel_latched(sel_latched), .sel_pulse(sel_pulse)
  );
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic       clk = 1'b0, rst = 1'b1, en = 1'b0, start_set = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] presc_sel = 3'd0;
  logic       trig_in = 1'b0, flag_clr = 1'b0;
  logic [3:0] sel_in = 4'd0;
  logic [9:0] data_in = 10'd0;
  logic       adc_clk, start_bit, busy, done_flag, sample_stb, sel_pulse;
  logic [9:0] result;
  logic [3:0] sel_latched;

  int checks = 0, fails = 0;
  int ncyc = 0;
  int t_latch = 0, t_stb = 0, t_flag = 0, n_latch = 0, n_flag = 0;
  int t_ac0 = 0, t_ac1 = 0;
  logic flag_prev = 1'b0, ac_prev = 1'b0;
  logic finished = 1'b0;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .en(en), .start_set(start_set), .mode(mode),
    .presc_sel(presc_sel), .trig_in(trig_in), .flag_clr(flag_clr),
    .sel_in(sel_in), .data_in(data_in), .adc_clk(adc_clk),
    .start_bit(start_bit), .busy(busy), .done_flag(done_flag),
    .result(result), .sample_stb(sample_stb), .sel_latched(sel_latched),
    .sel_pulse(sel_pulse)
  );

  always #2 clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  always @(negedge clk) begin
    if (sel_pulse) begin t_latch <= ncyc; n_latch <= n_latch + 1; end
    if (sample_stb) t_stb <= ncyc;
    if (done_flag && !flag_prev) begin t_flag <= ncyc; n_flag <= n_flag + 1; end
    if (adc_clk && !ac_prev) begin t_ac0 <= t_ac1; t_ac1 <= ncyc; end
    flag_prev <= done_flag;
    ac_prev   <= adc_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_start();
    start_set = 1'b1; step(1); start_set = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  // waits for done_flag; alters sel_in and data_in after the latch and strobe
  task automatic wait_done(input logic [3:0] late_sel, input logic [9:0] late_data);
    int k = 0;
    while (!done_flag && k < 3000) begin
      step(1);
      if (sel_pulse) sel_in = late_sel;
      if (sample_stb) data_in = late_data;
      k++;
    end
    chk(k < 3000, "watchdog wait_done", k, 0);
    step(1);
  endtask

  task automatic t_reset();
    step(3);
    chk(!busy && !done_flag && !start_bit, "reset state", {busy, done_flag, start_bit}, 0);
    chk(result == 10'd0 && !sample_stb && !sel_pulse, "reset outputs", int'(result), 0);
    step(5);
    chk(!adc_clk, "R1 clock low while disabled", adc_clk, 0);
  endtask

  task automatic t_first_single();
    int tw;
    en = 1'b1; mode = 2'd0; presc_sel = 3'd0; sel_in = 4'd5; data_in = 10'h2A5;
    step(4);
    write_start(); tw = ncyc - 1;
    wait_done(4'd9, 10'h111);
    chk(t_latch - tw >= 1 && t_latch - tw <= 2, "R2 start latency", t_latch - tw, 2);
    chk(t_flag - t_latch == 50, "R4 first length", t_flag - t_latch, 50);
    chk(t_stb - t_latch == 27, "R5 first strobe", t_stb - t_latch, 27);
    chk(result == 10'h2A5, "R5 R6 sampled result", int'(result), 'h2A5);
    chk(sel_latched == 4'd5, "R12 selection held", int'(sel_latched), 5);
    chk(!start_bit && !busy, "R7 start bit cleared", start_bit, 0);
    clear_flag();
    chk(!done_flag, "R6 flag cleared by write", done_flag, 0);
  endtask

  task automatic t_normal();
    presc_sel = 3'd2; data_in = 10'h0C3; sel_in = 4'd3;
    step(20);
    chk(t_ac1 - t_ac0 == 8, "R1 period sel 2", t_ac1 - t_ac0, 8);
    write_start();
    wait_done(4'd1, 10'h3FF);
    chk(t_flag - t_latch == 104, "R3 normal length", t_flag - t_latch, 104);
    chk(t_stb - t_latch == 28, "R5 normal strobe", t_stb - t_latch, 28);
    chk(result == 10'h0C3, "R5 result", int'(result), 'h0C3);
    chk(sel_latched == 4'd3, "R12 second selection", int'(sel_latched), 3);
    clear_flag();
    presc_sel = 3'd7; step(400);
    chk(t_ac1 - t_ac0 == 128, "R1 period sel 7", t_ac1 - t_ac0, 128);
    presc_sel = 3'd0; step(4);
  endtask

  task automatic t_free();
    int tl2;
    mode = 2'd1; data_in = 10'h155;
    write_start();
    wait_done(4'd2, 10'h155);
    chk(t_latch == t_flag, "R8 immediate restart", t_latch, t_flag);
    chk(start_bit && busy, "R8 start bit kept", start_bit, 1);
    tl2 = t_latch;
    clear_flag();
    wait_done(4'd2, 10'h155);
    chk(t_flag - tl2 == 26, "R8 follow-on length", t_flag - tl2, 26);
    mode = 2'd0; clear_flag();
    wait_done(4'd2, 10'h155);
    step(4);
    chk(!busy && !start_bit, "R8 stops after single", busy, 0);
    clear_flag();
  endtask

  task automatic t_trig();
    int t0, nl;
    mode = 2'd2; data_in = 10'h2C8; step(3);
    trig_in = 1'b1; t0 = ncyc;
    wait_done(4'd0, 10'h001);
    chk(t_latch - t0 == 4, "R9 trigger to start", t_latch - t0, 4);
    chk(t_stb - t_latch == 4, "R9 trigger strobe", t_stb - t_latch, 4);
    chk(t_flag - t_latch == 23, "R9 trigger length", t_flag - t_latch, 23);
    chk(result == 10'h2C8, "R9 trigger result", int'(result), 'h2C8);
    clear_flag();
    trig_in = 1'b0; step(4);
    trig_in = 1'b1; nl = n_latch;
    step(9); trig_in = 1'b0; step(3); trig_in = 1'b1;
    step(6);
    chk(n_latch == nl + 1, "R10 edge ignored while busy", n_latch, nl + 1);
    wait_done(4'd0, 10'h001);
    step(10);
    chk(!busy && n_latch == nl + 1, "R10 no late start", n_latch, nl + 1);
    trig_in = 1'b0; clear_flag();
    mode = 2'd0; step(4); nl = n_latch;
    trig_in = 1'b1; step(12); trig_in = 1'b0;
    chk(n_latch == nl && !busy, "R10 edge ignored in single", n_latch, nl);
  endtask

  task automatic t_abort();
    int nf;
    write_start(); step(12);
    nf = n_flag;
    en = 1'b0; step(1);
    chk(!busy && !start_bit, "R11 abort clears", {busy, start_bit}, 0);
    step(60);
    chk(n_flag == nf && !done_flag, "R11 no flag after abort", n_flag, nf);
    en = 1'b1; step(2);
    write_start();
    wait_done(4'd0, 10'h0);
    chk(t_flag - t_latch == 50, "R11 R4 first again", t_flag - t_latch, 50);
    clear_flag(); step(2);
  endtask

  initial begin
    step(4); rst = 1'b0;
    t_reset();
    t_first_single();
    t_normal();
    t_free();
    t_trig();
    t_abort();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule